// File: doc/BRIEF.md
# PHY link configuration sequencer

This block brings an Ethernet PHY out of reset and settles the link mode without software. After a start pulse it issues management-register accesses one at a time over a simple request/acknowledge port. It waits for any reset already in progress and then soft-resets the PHY, keeping every other control bit. Next it either forces the slowest mode or waits for autonegotiation to finish. Speed and duplex are then resolved from the local and partner ability registers.

The result appears as three mode flags, and the same flags are also packed into a MAC control word. A single time budget, counted in clock cycles from the start pulse, bounds every polling loop. When the budget runs out during either reset poll, the run ends with a fail flag. When it runs out while waiting for autonegotiation, the mode is taken from the speed and duplex bits the PHY control register currently holds. A parameter says whether the attached MAC supports gigabit operation. If it does not and the PHY has resolved gigabit, the block falls back and rewrites the PHY control register.

Top module: `phy_linkup_seq`

## Requirements
- R1: After reset every output is 0 and no access is requested. A start pulse while idle begins a run, and the first access is a read of register 0, requested one cycle after start is sampled.
- R2: Register 0 is read until its bit 15 (reset in progress) is 0. The read value with bit 15 set is then written back to register 0.
- R3: Register 0 is read again until bit 15 is 0. If bit 12 (autonegotiation enable) of that value is 0, register 0 is written with 0, all mode flags stay 0, and the run completes without failure.
- R4: Otherwise register 1 is read until bit 5 (negotiation complete) is 1. Registers 9 and 10 are read only when that value has bit 8 (extended status) set.
- R5: Gigabit full duplex is chosen when register 9 bit 9 and register 10 bit 11 are both 1. Gigabit half duplex is chosen when register 9 bit 8 and register 10 bit 10 are both 1. Half duplex wins when both pairs match.
- R6: Registers 4 and 5 are read when gigabit was not chosen or the MAC is not gigabit capable. The 100 full pair is bit 8 in both: it sets 100 Mbit and full duplex. The 100 half pair is bit 7 in both: it sets 100 Mbit and half duplex. The 10 full pair is bit 6 in both: it sets full duplex only. These apply in that order, each later match overriding earlier ones.
- R7: With a MAC that is not gigabit capable, a gigabit result clears the gigabit and full-duplex flags. It also writes register 0 with the 100 Mbit flag in bit 13 and zeros elsewhere. A gigabit-capable MAC never issues this write.
- R8: If the budget has expired when a register 1 poll still shows negotiation incomplete, register 0 is read. Gigabit is then bit 6 set with bit 13 clear, 100 Mbit is bit 13 set with bit 6 clear, and full duplex is bit 8. The run completes without failure.
- R9: If the budget has expired when a register 0 reset poll still shows bit 15 set, the run completes with fail high and all mode flags 0.
- R10: The budget is CLK_KHZ*TIMEOUT_MS clock cycles from the start pulse. No timeout outcome happens earlier.
- R11: done is a one-cycle pulse at the end of each run. The flags hold until the next start and are never gigabit and 100 Mbit together. mac_ctrl carries gigabit in bit 8, 100 Mbit in bit 7 and full duplex in bit 4, with all other bits 0.
- R12: While a request is pending without acknowledge, the request, direction, address and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| start | input | 1 | Begins a run when idle |
| mdio_req | output | 1 | Management access requested |
| mdio_wr | output | 1 | 1 = write, 0 = read |
| mdio_addr | output | 5 | PHY register number |
| mdio_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | Access finished; read data valid this cycle |
| mdio_rdata | input | 16 | Read data |
| link_gbit | output | 1 | Gigabit mode resolved |
| link_100 | output | 1 | 100 Mbit mode resolved |
| link_fd | output | 1 | Full duplex resolved |
| mac_ctrl | output | CTRL_W | Mode flags packed as MAC control bits |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Run ended by a reset-poll timeout |

## Verification
Every combination of the gigabit and 10/100 ability bits is swept against both a gigabit-capable and a 10/100-only MAC. A wrong priority order, for example letting full duplex beat half duplex or letting a 10 full match clear the speed, shows up as a wrong flag in some combination. A missing fallback leaves a 10/100 MAC reporting gigabit or omits the rewrite of register 0. The timeout paths are pushed with a PHY that never leaves reset or never finishes negotiating. A budget checked too early, or applied to the wrong loop, gives a premature or missing fail, or forced-mode bits taken from the wrong positions. The soft-reset write is compared with the value read, so a design that drops the preserved bits is caught.

// File: rtl/phy_linkup_pkg.sv
package phy_linkup_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_RD0A, S_WRRST, S_RD0B, S_WRFORCE, S_RD1, S_RDTO,
      S_RD9, S_RD10, S_RD4, S_RD5, S_WRDOWN, S_FIN
   } seq_state_t;

   // PHY register numbers
   localparam logic [4:0] RA_CTRL  = 5'd0;
   localparam logic [4:0] RA_STAT  = 5'd1;
   localparam logic [4:0] RA_ADV   = 5'd4;
   localparam logic [4:0] RA_LP    = 5'd5;
   localparam logic [4:0] RA_GADV  = 5'd9;
   localparam logic [4:0] RA_GLP   = 5'd10;

   // bit positions inside PHY registers
   localparam int B_RST    = 15;
   localparam int B_SEL100 = 13;
   localparam int B_ANEN   = 12;
   localparam int B_FDX    = 8;
   localparam int B_SEL1G  = 6;
   localparam int B_ANDONE = 5;
   localparam int B_EXTST  = 8;
   localparam int B_GADV_F = 9;
   localparam int B_GADV_H = 8;
   localparam int B_GLP_F  = 11;
   localparam int B_GLP_H  = 10;
   localparam int B_100F   = 8;
   localparam int B_100H   = 7;
   localparam int B_10F    = 6;

   // MAC control word bit positions
   localparam int CB_GBIT  = 8;
   localparam int CB_100   = 7;
   localparam int CB_FD    = 4;

endpackage

// File: rtl/phy_linkup_timer.sv
module phy_linkup_timer #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= CW'(LIMIT);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CW'(1);
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/phy_linkup_gres.sv
module phy_linkup_gres (
   input  logic adv_f,
   input  logic adv_h,
   input  logic lp_f,
   input  logic lp_h,
   output logic gb,
   output logic fd
);
   logic m_full, m_half;

   assign m_full = adv_f & lp_f;
   assign m_half = adv_h & lp_h;
   assign gb     = m_full | m_half;
   // half-duplex match has the last word
   assign fd     = m_half ? 1'b0 : m_full;
endmodule

// File: rtl/phy_linkup_fres.sv
module phy_linkup_fres (
   input  logic [2:0] adv,     // {100F, 100H, 10F}
   input  logic [2:0] lp,      // {100F, 100H, 10F}
   input  logic       fd_in,
   output logic       sp,
   output logic       fd
);
   logic [2:0] m;

   assign m  = adv & lp;
   assign sp = m[2] | m[1];

   always_comb begin
      fd = fd_in;
      if (m[2]) fd = 1'b1;
      if (m[1]) fd = 1'b0;
      if (m[0]) fd = 1'b1;
   end
endmodule

// File: rtl/phy_linkup_seq.sv
module phy_linkup_seq
   import phy_linkup_pkg::*;
#(
   parameter int unsigned CLK_KHZ    = 100000,
   parameter int unsigned TIMEOUT_MS = 3000,
   parameter bit          MAC_GBIT   = 1'b1,
   parameter int          CTRL_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              mdio_req,
   output logic              mdio_wr,
   output logic [4:0]        mdio_addr,
   output logic [15:0]       mdio_wdata,
   input  logic              mdio_ack,
   input  logic [15:0]       mdio_rdata,
   output logic              link_gbit,
   output logic              link_100,
   output logic              link_fd,
   output logic [CTRL_W-1:0] mac_ctrl,
   output logic              done,
   output logic              fail
);
   localparam int unsigned LIMIT = CLK_KHZ * TIMEOUT_MS;

   if (CLK_KHZ == 0 || TIMEOUT_MS == 0) begin : g_bad_budget
      $error("phy_linkup_seq: time budget must be non-zero");
   end
   if (CTRL_W <= CB_GBIT) begin : g_bad_ctrl
      $error("phy_linkup_seq: CTRL_W too narrow for mode bits");
   end

   seq_state_t  st_q;
   logic [15:0] ctl_q;
   logic [1:0]  gadv_q;
   logic [2:0]  adv_q;
   logic        gb_q, sp_q, fd_q, fail_q;
   logic        expired, tmr_load;
   logic        g_gb, g_fd, f_sp, f_fd;
   logic        need_fe, need_dn;

   assign tmr_load = (st_q == S_IDLE) && start;

   phy_linkup_timer #(.LIMIT(LIMIT)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .expired(expired)
   );

   phy_linkup_gres u_gres (
      .adv_f(gadv_q[1]), .adv_h(gadv_q[0]),
      .lp_f(mdio_rdata[B_GLP_F]), .lp_h(mdio_rdata[B_GLP_H]),
      .gb(g_gb), .fd(g_fd)
   );

   phy_linkup_fres u_fres (
      .adv(adv_q),
      .lp({mdio_rdata[B_100F], mdio_rdata[B_100H], mdio_rdata[B_10F]}),
      .fd_in(fd_q), .sp(f_sp), .fd(f_fd)
   );

   if (MAC_GBIT) begin : g_gmac
      assign need_fe = ~g_gb;
      assign need_dn = 1'b0;
   end else begin : g_femac
      assign need_fe = 1'b1;
      assign need_dn = gb_q;
   end

   always_comb begin
      mdio_req   = 1'b1;
      mdio_wr    = 1'b0;
      mdio_addr  = RA_CTRL;
      mdio_wdata = '0;
      case (st_q)
         S_RD0A, S_RD0B, S_RDTO: mdio_addr = RA_CTRL;
         S_WRRST: begin
            mdio_wr    = 1'b1;
            mdio_wdata = ctl_q | 16'h8000;
         end
         S_WRFORCE: mdio_wr = 1'b1;
         S_RD1:  mdio_addr = RA_STAT;
         S_RD9:  mdio_addr = RA_GADV;
         S_RD10: mdio_addr = RA_GLP;
         S_RD4:  mdio_addr = RA_ADV;
         S_RD5:  mdio_addr = RA_LP;
         S_WRDOWN: begin
            mdio_wr              = 1'b1;
            mdio_wdata[B_SEL100] = sp_q;
         end
         default: mdio_req = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         ctl_q  <= '0;
         gadv_q <= '0;
         adv_q  <= '0;
         gb_q   <= 1'b0;
         sp_q   <= 1'b0;
         fd_q   <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         case (st_q)
            S_IDLE: if (start) begin
               st_q   <= S_RD0A;
               gb_q   <= 1'b0;
               sp_q   <= 1'b0;
               fd_q   <= 1'b0;
               fail_q <= 1'b0;
            end
            S_RD0A: if (mdio_ack) begin
               if (mdio_rdata[B_RST]) begin
                  if (expired) begin
                     fail_q <= 1'b1;
                     st_q   <= S_FIN;
                  end
               end else begin
                  ctl_q <= mdio_rdata;
                  st_q  <= S_WRRST;
               end
            end
            S_WRRST: if (mdio_ack) st_q <= S_RD0B;
            S_RD0B: if (mdio_ack) begin
               if (mdio_rdata[B_RST]) begin
                  if (expired) begin
                     fail_q <= 1'b1;
                     st_q   <= S_FIN;
                  end
               end else if (!mdio_rdata[B_ANEN])
                  st_q <= S_WRFORCE;
               else
                  st_q <= S_RD1;
            end
            S_WRFORCE: if (mdio_ack) st_q <= S_FIN;
            S_RD1: if (mdio_ack) begin
               if (!mdio_rdata[B_ANDONE]) begin
                  if (expired) st_q <= S_RDTO;
               end else
                  st_q <= mdio_rdata[B_EXTST] ? S_RD9 : S_RD4;
            end
            S_RDTO: if (mdio_ack) begin
               gb_q <= mdio_rdata[B_SEL1G] & ~mdio_rdata[B_SEL100];
               sp_q <= ~mdio_rdata[B_SEL1G] & mdio_rdata[B_SEL100];
               fd_q <= mdio_rdata[B_FDX];
               st_q <= S_FIN;
            end
            S_RD9: if (mdio_ack) begin
               gadv_q <= {mdio_rdata[B_GADV_F], mdio_rdata[B_GADV_H]};
               st_q   <= S_RD10;
            end
            S_RD10: if (mdio_ack) begin
               gb_q <= g_gb;
               fd_q <= g_fd;
               st_q <= need_fe ? S_RD4 : S_FIN;
            end
            S_RD4: if (mdio_ack) begin
               adv_q <= {mdio_rdata[B_100F], mdio_rdata[B_100H], mdio_rdata[B_10F]};
               st_q  <= S_RD5;
            end
            S_RD5: if (mdio_ack) begin
               sp_q <= f_sp;
               if (need_dn) begin
                  gb_q <= 1'b0;
                  fd_q <= 1'b0;
                  st_q <= S_WRDOWN;
               end else begin
                  fd_q <= f_fd;
                  st_q <= S_FIN;
               end
            end
            S_WRDOWN: if (mdio_ack) st_q <= S_FIN;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mac_ctrl           = '0;
      mac_ctrl[CB_GBIT]  = gb_q;
      mac_ctrl[CB_100]   = sp_q;
      mac_ctrl[CB_FD]    = fd_q;
   end

   assign link_gbit = gb_q;
   assign link_100  = sp_q;
   assign link_fd   = fd_q;
   assign done      = (st_q == S_FIN);
   assign fail      = fail_q;
endmodule

// File: rtl/phy_linkup_chk.sv
module phy_linkup_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mdio_req,
   input logic        mdio_wr,
   input logic [4:0]  mdio_addr,
   input logic [15:0] mdio_wdata,
   input logic        mdio_ack,
   input logic        link_gbit,
   input logic        link_100,
   input logic        link_fd,
   input logic        done,
   input logic        fail
);
   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_wr) &&
                                   $stable(mdio_addr) && $stable(mdio_wdata)));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(link_gbit && link_100));

   // R9
   fail_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (!link_gbit && !link_100 && !link_fd));

   // R1
   idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !mdio_req);
endmodule

bind phy_linkup_seq phy_linkup_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mdio_req(mdio_req), .mdio_wr(mdio_wr),
   .mdio_addr(mdio_addr), .mdio_wdata(mdio_wdata), .mdio_ack(mdio_ack),
   .link_gbit(link_gbit), .link_100(link_100), .link_fd(link_fd),
   .done(done), .fail(fail)
);

// File: tb/phy_linkup_phy_model.sv
module phy_linkup_phy_model #(
   parameter int LAT = 2
) (
   input  logic        clk,
   input  logic        req,
   input  logic        wr,
   input  logic [4:0]  addr,
   input  logic [15:0] wdata,
   output logic        ack,
   output logic [15:0] rdata
);
   logic [15:0] regs [0:15];
   int          busy, post_busy, an_wait, wr_cnt;
   logic [4:0]  wlog_a [0:3];
   logic [15:0] wlog_d [0:3];
   bit          saw9, saw4;

   initial begin
      ack = 1'b0;
      rdata = '0;
      busy = 0; post_busy = 0; an_wait = 0; wr_cnt = 0;
      saw9 = 0; saw4 = 0;
      for (int i = 0; i < 16; i++) regs[i] = '0;
      forever begin
         @(negedge clk);
         if (req) begin
            logic [4:0]  a;
            logic [15:0] d;
            logic        w;
            a = addr; d = wdata; w = wr;
            repeat (LAT) @(negedge clk);
            if (w) begin
               if (wr_cnt < 4) begin
                  wlog_a[wr_cnt] = a;
                  wlog_d[wr_cnt] = d;
               end
               wr_cnt++;
               if (a == 5'd0) begin
                  regs[0] = d & 16'h7fff;
                  if (d[15]) busy = post_busy;
               end
               rdata = '0;
            end else begin
               if (a == 5'd9) saw9 = 1;
               if (a == 5'd4) saw4 = 1;
               if (a == 5'd0) begin
                  if (busy > 0) begin
                     busy--;
                     rdata = regs[0] | 16'h8000;
                  end else rdata = regs[0];
               end else if (a == 5'd1) begin
                  if (an_wait > 0) begin
                     an_wait--;
                     rdata = regs[1] & 16'hffdf;
                  end else rdata = regs[1];
               end else rdata = regs[a[3:0]];
            end
            ack = 1'b1;
            @(negedge clk);
            ack = 1'b0;
         end
      end
   end
endmodule

// File: tb/phy_linkup_seq_bench.sv
module phy_linkup_seq_bench;
   localparam int TO = 300;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;

   logic        req_a, wr_a, ack_a, gb_a, sp_a, fd_a, done_a, fail_a;
   logic [4:0]  addr_a;
   logic [15:0] wd_a, rd_a, ctl_a;
   logic        req_b, wr_b, ack_b, gb_b, sp_b, fd_b, done_b, fail_b;
   logic [4:0]  addr_b;
   logic [15:0] wd_b, rd_b, ctl_b;

   int checks = 0, failures = 0, cyc = 0, start_cyc = 0;
   bit got_a, got_b;
   logic [2:0]  cm_a, cm_b;
   logic [15:0] cc_a, cc_b;
   logic        cf_a, cf_b;
   int          dur_a, dur_b;

   always #5 clk = ~clk;

   phy_linkup_seq #(.CLK_KHZ(1), .TIMEOUT_MS(TO), .MAC_GBIT(1'b1)) u_phy_linkup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mdio_req(req_a), .mdio_wr(wr_a),
      .mdio_addr(addr_a), .mdio_wdata(wd_a), .mdio_ack(ack_a), .mdio_rdata(rd_a),
      .link_gbit(gb_a), .link_100(sp_a), .link_fd(fd_a), .mac_ctrl(ctl_a),
      .done(done_a), .fail(fail_a));

   phy_linkup_seq #(.CLK_KHZ(1), .TIMEOUT_MS(TO), .MAC_GBIT(1'b0)) u_phy_linkup_seq_fe (
      .clk(clk), .rst_n(rst_n), .start(start), .mdio_req(req_b), .mdio_wr(wr_b),
      .mdio_addr(addr_b), .mdio_wdata(wd_b), .mdio_ack(ack_b), .mdio_rdata(rd_b),
      .link_gbit(gb_b), .link_100(sp_b), .link_fd(fd_b), .mac_ctrl(ctl_b),
      .done(done_b), .fail(fail_b));

   phy_linkup_phy_model u_m_a (.clk(clk), .req(req_a), .wr(wr_a), .addr(addr_a),
      .wdata(wd_a), .ack(ack_a), .rdata(rd_a));
   phy_linkup_phy_model u_m_b (.clk(clk), .req(req_b), .wr(wr_b), .addr(addr_b),
      .wdata(wd_b), .ack(ack_b), .rdata(rd_b));

   initial forever begin
      @(posedge clk);
      cyc++;
   end

   initial forever begin
      @(negedge clk);
      if (done_a) begin
         got_a = 1; cm_a = {gb_a, sp_a, fd_a}; cc_a = ctl_a; cf_a = fail_a;
         dur_a = cyc - start_cyc;
      end
      if (done_b) begin
         got_b = 1; cm_b = {gb_b, sp_b, fd_b}; cc_b = ctl_b; cf_b = fail_b;
         dur_b = cyc - start_cyc;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] pack_ctl(input logic [2:0] m);
      return (16'(m[2]) << 8) | (16'(m[1]) << 7) | (16'(m[0]) << 4);
   endfunction

   // returns {downgrade_write, gb, sp, fd}
   function automatic logic [3:0] exp_mode(input bit macg, input bit ext,
      input logic [15:0] a1, input logic [15:0] p1,
      input logic [15:0] a, input logic [15:0] p);
      bit gb, sp, fd, dn;
      gb = 0; sp = 0; fd = 0; dn = 0;
      if (ext) begin
         if (a1[9] && p1[11]) begin gb = 1; fd = 1; end
         if (a1[8] && p1[10]) begin gb = 1; fd = 0; end
      end
      if (!gb || !macg) begin
         if (a[8] && p[8]) begin sp = 1; fd = 1; end
         if (a[7] && p[7]) begin sp = 1; fd = 0; end
         if (a[6] && p[6]) fd = 1;
         if (gb && !macg) begin gb = 0; fd = 0; dn = 1; end
      end
      return {dn, gb, sp, fd};
   endfunction

   task automatic setup(input logic [15:0] r0, input logic [15:0] r1,
      input logic [15:0] r4, input logic [15:0] r5, input logic [15:0] r9,
      input logic [15:0] r10, input int bz, input int pbz, input int anw);
      u_m_a.regs[0] = r0;  u_m_b.regs[0] = r0;
      u_m_a.regs[1] = r1;  u_m_b.regs[1] = r1;
      u_m_a.regs[4] = r4;  u_m_b.regs[4] = r4;
      u_m_a.regs[5] = r5;  u_m_b.regs[5] = r5;
      u_m_a.regs[9] = r9;  u_m_b.regs[9] = r9;
      u_m_a.regs[10] = r10; u_m_b.regs[10] = r10;
      u_m_a.busy = bz;     u_m_b.busy = bz;
      u_m_a.post_busy = pbz; u_m_b.post_busy = pbz;
      u_m_a.an_wait = anw; u_m_b.an_wait = anw;
      u_m_a.wr_cnt = 0;    u_m_b.wr_cnt = 0;
      u_m_a.saw9 = 0;      u_m_b.saw9 = 0;
      u_m_a.saw4 = 0;      u_m_b.saw4 = 0;
   endtask

   task automatic run();
      @(negedge clk);
      got_a = 0; got_b = 0;
      start = 1'b1;
      start_cyc = cyc;
      @(negedge clk);
      start = 1'b0;
      // R1: first access is a read of register 0
      chk(req_a && !wr_a && addr_a == 5'd0, "R1 first access",
          {req_a, wr_a, addr_a}, {1'b1, 1'b0, 5'd0});
      while (!(got_a && got_b)) @(negedge clk);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!req_a && !done_a && !fail_a && ctl_a == 16'h0 && {gb_a, sp_a, fd_a} == 3'b0,
          "R1 reset state", {req_a, done_a, fail_a, ctl_a}, 32'h0);

      // R5/R7 sweep: extended status set, all ability combinations
      for (int k = 0; k < 1024; k++) begin
         logic [15:0] r9, r10, r4, r5, r0;
         logic [3:0]  ea, eb;
         r9  = (16'(k[1]) << 9) | (16'(k[0]) << 8);
         r10 = (16'(k[3]) << 11) | (16'(k[2]) << 10);
         r4  = 16'(k[6:4]) << 6;
         r5  = 16'(k[9:7]) << 6;
         r0  = 16'h1000 | 16'(k[3:0]);
         setup(r0, 16'h0120, r4, r5, r9, r10, k % 2, k % 3, k % 3);
         run();
         ea = exp_mode(1'b1, 1'b1, r9, r10, r4, r5);
         eb = exp_mode(1'b0, 1'b1, r9, r10, r4, r5);
         chk(cm_a == ea[2:0] && !cf_a, "R5 gigabit MAC mode", {cf_a, cm_a}, {1'b0, ea[2:0]});
         chk(cm_b == eb[2:0] && !cf_b, "R7 10/100 MAC mode", {cf_b, cm_b}, {1'b0, eb[2:0]});
         chk(cc_a == pack_ctl(ea[2:0]), "R11 mac_ctrl", cc_a, pack_ctl(ea[2:0]));
         chk(u_m_a.wlog_d[0] == (r0 | 16'h8000) && u_m_a.wlog_a[0] == 5'd0,
             "R2 reset write", u_m_a.wlog_d[0], r0 | 16'h8000);
         chk(u_m_a.wr_cnt == 1, "R7 no rewrite with gigabit MAC", u_m_a.wr_cnt, 1);
         chk(u_m_a.saw4 == !ea[2], "R6 10/100 read skipped on gigabit", u_m_a.saw4, !ea[2]);
         if (eb[3])
            chk(u_m_b.wr_cnt == 2 && u_m_b.wlog_a[1] == 5'd0 &&
                u_m_b.wlog_d[1] == (16'(eb[1]) << 13), "R7 downgrade write",
                {u_m_b.wr_cnt[15:0], u_m_b.wlog_d[1]}, {16'd2, 16'(eb[1]) << 13});
         else
            chk(u_m_b.wr_cnt == 1, "R7 no downgrade write", u_m_b.wr_cnt, 1);
      end

      // R4/R6 sweep: no extended status
      for (int k = 0; k < 64; k++) begin
         logic [15:0] r4, r5;
         logic [3:0]  ea;
         r4 = 16'(k[2:0]) << 6;
         r5 = 16'(k[5:3]) << 6;
         setup(16'h1000, 16'h0020, r4, r5, 16'h0300, 16'h0c00, 0, 0, k % 2);
         run();
         ea = exp_mode(1'b1, 1'b0, 16'h0300, 16'h0c00, r4, r5);
         chk(cm_a == ea[2:0] && cm_b == ea[2:0], "R6 10/100 priority",
             {cm_a, cm_b}, {ea[2:0], ea[2:0]});
         chk(!u_m_a.saw9 && !u_m_b.saw9, "R4 gigabit regs skipped",
             {u_m_a.saw9, u_m_b.saw9}, 2'b00);
      end

      // R3 forced mode
      setup(16'h0140, 16'h0120, 16'h01c0, 16'h01c0, 16'h0300, 16'h0c00, 2, 1, 0);
      run();
      chk(cm_a == 3'b0 && cm_b == 3'b0 && !cf_a && !cf_b, "R3 forced mode flags",
          {cf_a, cm_a, cf_b, cm_b}, 8'h0);
      chk(u_m_a.wr_cnt == 2 && u_m_a.wlog_d[0] == 16'h8140 && u_m_a.wlog_d[1] == 16'h0,
          "R3 forced write", {u_m_a.wr_cnt[15:0], u_m_a.wlog_d[1]}, {16'd2, 16'h0});

      // R8/R10 autonegotiation timeout, all mode bit combinations
      for (int j = 0; j < 8; j++) begin
         logic [15:0] r0;
         logic [2:0]  em;
         r0 = 16'h1000 | (16'(j[0]) << 6) | (16'(j[1]) << 8) | (16'(j[2]) << 13);
         em = {j[0] & ~j[2], ~j[0] & j[2], j[1]};
         setup(r0, 16'h0120, 16'h01c0, 16'h01c0, 16'h0300, 16'h0c00, 0, 0, 100000);
         run();
         chk(cm_a == em && cm_b == em && !cf_a && !cf_b, "R8 timeout mode",
             {cf_a, cm_a, cf_b, cm_b}, {1'b0, em, 1'b0, em});
         chk(dur_a >= TO && dur_b >= TO, "R10 budget respected", dur_a, TO);
      end

      // R9 reset never clears before the soft reset
      setup(16'h1000, 16'h0120, 0, 0, 0, 0, 100000, 0, 0);
      run();
      chk(cf_a && cf_b && cm_a == 3'b0 && cm_b == 3'b0, "R9 fail on first poll",
          {cf_a, cm_a}, {1'b1, 3'b0});
      chk(u_m_a.wr_cnt == 0, "R9 no write before fail", u_m_a.wr_cnt, 0);
      chk(dur_a >= TO, "R10 fail not early", dur_a, TO);

      // R9 reset never clears after the soft reset
      setup(16'h1000, 16'h0120, 0, 0, 0, 0, 0, 100000, 0);
      run();
      chk(cf_a && cf_b && cc_a == 16'h0, "R9 fail on second poll",
          {cf_a, cc_a}, {1'b1, 16'h0});
      chk(u_m_a.wr_cnt == 1, "R9 single reset write", u_m_a.wr_cnt, 1);

      // R11 flags hold after done and clear of fail on next run
      repeat (5) @(negedge clk);
      chk(fail_a && !done_a && !req_a, "R11 result held", {fail_a, done_a, req_a}, 3'b100);
      setup(16'h1000, 16'h0020, 16'h0100, 16'h0100, 0, 0, 0, 0, 0);
      run();
      chk(!cf_a && cm_a == 3'b011, "R11 new run clears fail", {cf_a, cm_a}, 4'b0011);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule